// File: doc/BRIEF.md
# Box-Average Decimating Sample Reducer

This block takes 8-bit converter samples that arrive four at a time on a parallel word, one word per clock. It adds up non-overlapping groups of 2^n consecutive samples and produces one 16-bit result per group. The integer byte of each result holds the group mean on the 8-bit scale. The fraction byte keeps the extra resolution that averaging yields, instead of truncating it away. A one-clock strobe marks each result so that an acquisition memory can write it.

Two options are available. The first doubles every sample before it is summed and clips it at full scale. The second drops every other result, which halves the output rate once more. The window size and both options are captured only by a synchronous restart. Any partial window is thrown away at that point.

A window must hold at least one full input word, so n runs from 2 to 8. A restart that requests any other value puts the block into a flagged idle state. It stays there until a legal restart arrives. The asynchronous active-low reset is expected to be released synchronously to `clk` by the reset tree upstream.

Top module: `boxavg_decimator`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `out_avg` is 0 and `cfg_illegal` is 0. The default settings are n = 2, gain off and halving off.
- R2: Each result is the sum of the 2^n samples in one window, shifted left by (8 − n), as unsigned 8.8 fixed point. A window of all 255 samples therefore gives 0xFF00.
- R3: Windows do not overlap. Exactly one result is produced per 2^n/4 accepted words. `out_valid` is high for one cycle, in the cycle after the clock edge that accepts the last word of the window.
- R4: A word is accepted only on a clock edge where `in_valid` is 1. A cycle with `in_valid` low does not advance the window.
- R5: With gain enabled, each sample s contributes min(2·s, 255) to the sum.
- R6: With halving enabled, the first completed window after a restart is dropped and the second is emitted. The pattern then continues to alternate.
- R7: A clock edge with `restart` high captures `cfg_log_win`, `cfg_gain2x` and `cfg_halve`. It clears any partial window, ignores the word presented on that edge and forces `out_valid` low in the next cycle.
- R8: The three configuration inputs have no effect on any edge where `restart` is low.
- R9: A restart with `cfg_log_win` below 2 or above 8 sets `cfg_illegal` to 1 in the following cycle. While the flag is set, no result is produced. The next legal restart clears the flag.
- R10: `out_avg` keeps its value in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one quarter of the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart that captures the configuration |
| cfg_log_win | input | 4 | Window exponent n; the window is 2^n samples |
| cfg_gain2x | input | 1 | Doubles each sample with saturation |
| cfg_halve | input | 1 | Emits only every second result |
| in_valid | input | 1 | Input word qualifier |
| in_samples | input | 32 | Four 8-bit samples, lane 0 in bits 7:0 |
| out_valid | output | 1 | Write strobe for a new result |
| out_avg | output | 16 | Window mean, unsigned 8.8 |
| cfg_illegal | output | 1 | The last restart requested an unsupported window |

## Verification
A corrupted accumulator or a beat counter that is off by one shows at the ports no later than the end of the current window. It appears either as a wrong value on the next strobe or as a strobe arriving a word early or late. A window-phase or halving-phase error moves every later strobe, so the scoreboard sees it as an unexpected or missing result within one or two windows. A configuration captured outside a restart changes the result scaling at once, and the very next result exposes it.

// File: rtl/boxavg_pkg.sv
package boxavg_pkg;
  parameter int BA_SAMPLE_W = 8;
  parameter int BA_LANES    = 4;
  parameter int BA_MAX_LOG  = 8;
  parameter int BA_LOG_W    = 4;

  typedef enum logic {
    PH_DROP = 1'b0,
    PH_KEEP = 1'b1
  } halve_phase_e;
endpackage

// File: rtl/boxavg_beat_sum.sv
module boxavg_beat_sum #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 4,
  parameter int SUM_W    = 10
) (
  input  logic [LANES*SAMPLE_W-1:0] lanes_in,
  input  logic                      gain_en,
  output logic [SUM_W-1:0]          beat_sum
);
  logic [SAMPLE_W-1:0] scaled [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SAMPLE_W-1:0] raw;
    assign raw = lanes_in[g*SAMPLE_W +: SAMPLE_W];
    always_comb begin
      if (!gain_en) begin
        scaled[g] = raw;
      end else if (raw[SAMPLE_W-1]) begin
        scaled[g] = '1;
      end else begin
        scaled[g] = {raw[SAMPLE_W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    beat_sum = '0;
    for (int k = 0; k < LANES; k++) begin
      beat_sum = beat_sum + SUM_W'(scaled[k]);
    end
  end
endmodule

// File: rtl/boxavg_window_acc.sv
module boxavg_window_acc #(
  parameter int SUM_W     = 10,
  parameter int ACC_W     = 16,
  parameter int LOG_W     = 4,
  parameter int MAX_LOG   = 8,
  parameter int LOG_LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat_en,
  input  logic [SUM_W-1:0] beat_sum,
  input  logic [LOG_W-1:0] log_win,
  output logic             win_done,
  output logic [ACC_W-1:0] win_total
);
  localparam int CNT_W = MAX_LOG - LOG_LANES;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   span;
  logic             last_beat;

  always_comb begin
    span      = (CNT_W+1)'(1) << (log_win - LOG_W'(LOG_LANES));
    last_beat = (cnt_q == CNT_W'(span - 1'b1));
    win_total = acc_q + ACC_W'(beat_sum);
    win_done  = beat_en && last_beat;
  end

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clear) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (beat_en) begin
      if (last_beat) begin
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = win_total;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/boxavg_out_stage.sv
module boxavg_out_stage
  import boxavg_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int LOG_W   = 4,
  parameter int MAX_LOG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             win_done,
  input  logic [ACC_W-1:0] win_total,
  input  logic [LOG_W-1:0] log_win,
  input  logic             halve,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_avg
);
  halve_phase_e     phase_q, phase_d;
  logic             valid_d;
  logic [ACC_W-1:0] avg_d;
  logic             emit;

  always_comb begin
    emit    = win_done && (!halve || (phase_q == PH_KEEP));
    valid_d = emit;
    avg_d   = emit ? (win_total << (LOG_W'(MAX_LOG) - log_win)) : out_avg;
    phase_d = phase_q;
    if (clear) begin
      phase_d = PH_DROP;
    end else if (win_done) begin
      phase_d = (phase_q == PH_DROP) ? PH_KEEP : PH_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_DROP;
      out_valid <= 1'b0;
      out_avg   <= '0;
    end else begin
      phase_q   <= phase_d;
      out_valid <= valid_d;
      out_avg   <= avg_d;
    end
  end
endmodule

// File: rtl/boxavg_decimator.sv
module boxavg_decimator
  import boxavg_pkg::*;
#(
  parameter int SAMPLE_W = BA_SAMPLE_W,
  parameter int LANES    = BA_LANES,
  parameter int MAX_LOG  = BA_MAX_LOG,
  parameter int LOG_W    = BA_LOG_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        restart,
  input  logic [LOG_W-1:0]            cfg_log_win,
  input  logic                        cfg_gain2x,
  input  logic                        cfg_halve,
  input  logic                        in_valid,
  input  logic [LANES*SAMPLE_W-1:0]   in_samples,
  output logic                        out_valid,
  output logic [SAMPLE_W+MAX_LOG-1:0] out_avg,
  output logic                        cfg_illegal
);
  localparam int LOG_LANES = $clog2(LANES);
  localparam int SUM_W     = SAMPLE_W + LOG_LANES;
  localparam int ACC_W     = SAMPLE_W + MAX_LOG;

  logic [LOG_W-1:0] log_q, log_d;
  logic             gain_q, gain_d;
  logic             halve_q, halve_d;
  logic             illegal_q, illegal_d;
  logic             beat_en;
  logic [SUM_W-1:0] beat_sum;
  logic             win_done;
  logic [ACC_W-1:0] win_total;

  // configuration capture: next state
  always_comb begin
    log_d     = log_q;
    gain_d    = gain_q;
    halve_d   = halve_q;
    illegal_d = illegal_q;
    if (restart) begin
      log_d     = cfg_log_win;
      gain_d    = cfg_gain2x;
      halve_d   = cfg_halve;
      illegal_d = (cfg_log_win < LOG_W'(LOG_LANES)) ||
                  (cfg_log_win > LOG_W'(MAX_LOG));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_q     <= LOG_W'(LOG_LANES);
      gain_q    <= 1'b0;
      halve_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      log_q     <= log_d;
      gain_q    <= gain_d;
      halve_q   <= halve_d;
      illegal_q <= illegal_d;
    end
  end

  assign beat_en     = in_valid && !restart && !illegal_q;
  assign cfg_illegal = illegal_q;

  boxavg_beat_sum #(
    .SAMPLE_W(SAMPLE_W), .LANES(LANES), .SUM_W(SUM_W)
  ) i_beat_sum (
    .lanes_in(in_samples), .gain_en(gain_q), .beat_sum(beat_sum)
  );

  boxavg_window_acc #(
    .SUM_W(SUM_W), .ACC_W(ACC_W), .LOG_W(LOG_W),
    .MAX_LOG(MAX_LOG), .LOG_LANES(LOG_LANES)
  ) i_window_acc (
    .clk(clk), .rst_n(rst_n), .clear(restart), .beat_en(beat_en),
    .beat_sum(beat_sum), .log_win(log_q),
    .win_done(win_done), .win_total(win_total)
  );

  boxavg_out_stage #(
    .ACC_W(ACC_W), .LOG_W(LOG_W), .MAX_LOG(MAX_LOG)
  ) i_out_stage (
    .clk(clk), .rst_n(rst_n), .clear(restart), .win_done(win_done),
    .win_total(win_total), .log_win(log_q), .halve(halve_q),
    .out_valid(out_valid), .out_avg(out_avg)
  );
endmodule

// File: rtl/boxavg_checker.sv
module boxavg_checker #(
  parameter int SAMPLE_W = 8,
  parameter int MAX_LOG  = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        restart,
  input logic                        in_valid,
  input logic                        out_valid,
  input logic [SAMPLE_W+MAX_LOG-1:0] out_avg,
  input logic                        cfg_illegal
);
  localparam logic [SAMPLE_W+MAX_LOG-1:0] FULL_SCALE =
    {{SAMPLE_W{1'b1}}, {MAX_LOG{1'b0}}};

  assert_max_scale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_avg <= FULL_SCALE));

  assert_strobe_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !restart));

  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid);

  assert_illegal_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> !out_valid);

  assert_illegal_from_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_illegal) |-> $past(restart));

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_avg));
endmodule

bind boxavg_decimator boxavg_checker #(
  .SAMPLE_W(SAMPLE_W), .MAX_LOG(MAX_LOG)
) i_boxavg_checker (
  .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
  .out_valid(out_valid), .out_avg(out_avg), .cfg_illegal(cfg_illegal)
);

// File: tb/test_boxavg_decimator.sv
module test_boxavg_decimator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic [3:0]  cfg_log_win = 4'd2;
  logic        cfg_gain2x = 1'b0;
  logic        cfg_halve = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_samples = '0;
  logic        out_valid;
  logic [15:0] out_avg;
  logic        cfg_illegal;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit mon_on = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] last_avg = '0;

  // reference model state
  int m_n = 2; bit m_g = 0; bit m_h = 0; bit m_bad = 0;
  int m_sum = 0; int m_cnt = 0; int m_idx = 0;

  always #5 clk = ~clk;

  boxavg_decimator i_boxavg_decimator (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_log_win(cfg_log_win),
    .cfg_gain2x(cfg_gain2x), .cfg_halve(cfg_halve), .in_valid(in_valid),
    .in_samples(in_samples), .out_valid(out_valid), .out_avg(out_avg),
    .cfg_illegal(cfg_illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sat2(input int s, input bit g);
    if (!g) return s;
    return (s > 127) ? 255 : 2 * s;
  endfunction

  task automatic word(input logic [31:0] w, input bit v, input string tag);
    @(negedge clk);
    restart = 1'b0; in_valid = v; in_samples = w;
    if (v && !m_bad) begin
      for (int k = 0; k < 4; k++) m_sum += sat2(int'(w[8*k +: 8]), m_g);
      m_cnt += 4;
      if (m_cnt == (1 << m_n)) begin
        if (!m_h || (m_idx % 2 == 1)) begin
          exp_q.push_back(16'(m_sum << (8 - m_n)));
          tag_q.push_back(tag);
        end
        m_idx++; m_sum = 0; m_cnt = 0;
      end
    end
  endtask

  task automatic do_restart(input int n, input bit g, input bit h);
    @(negedge clk);
    restart = 1'b1; cfg_log_win = 4'(n); cfg_gain2x = g; cfg_halve = h;
    in_valid = 1'b1; in_samples = 32'hFFFF_FFFF;  // must be ignored (R7)
    m_n = n; m_g = g; m_h = h; m_bad = (n < 2) || (n > 8);
    m_sum = 0; m_cnt = 0; m_idx = 0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) word(32'h0, 1'b0, "idle");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R3 unexpected result", out_avg, 32'hDEAD);
        end else begin
          check(tag_q.pop_front(), out_avg, exp_q.pop_front());
        end
      end else begin
        check("R10 hold", out_avg, last_avg);
      end
      last_avg = out_avg;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 out_avg in reset", out_avg, 0);
    check("R1 cfg_illegal in reset", cfg_illegal, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    mon_on = 1;

    // R1/R2: defaults n=2, one result per word
    word(32'h04030201, 1, "R1 default n2");
    word(32'hFFFFFFFF, 1, "R2 n2 full scale");
    word(32'h80402010, 1, "R2 n2 mixed");
    idle(2);

    // R4: n=3 with stalls
    do_restart(3, 0, 0);
    for (int i = 0; i < 12; i++) begin
      word($urandom, 1, "R4 n3 stream");
      if (i % 3 == 0) word($urandom, 0, "R4 stall");
    end
    idle(2);

    // R2: n=8, full scale, zero, random
    do_restart(8, 0, 0);
    for (int i = 0; i < 64; i++) word(32'hFFFFFFFF, 1, "R2 n8 full");
    for (int i = 0; i < 64; i++) word(32'h0, 1, "R2 n8 zero");
    for (int i = 0; i < 64; i++) word($urandom, 1, "R2 n8 random");
    idle(2);

    // R5: gain with saturation
    do_restart(4, 1, 0);
    word(32'h7F80FF01, 1, "R5 gain sat"); word(32'h40C03F00, 1, "R5 gain sat");
    word(32'h7F80FF01, 1, "R5 gain sat"); word(32'h11223344, 1, "R5 gain sat");
    for (int i = 0; i < 8; i++) word($urandom, 1, "R5 gain random");
    idle(2);

    // R6: halving
    do_restart(2, 0, 1);
    for (int i = 0; i < 7; i++) word(32'h01010101 * (i + 1), 1, "R6 halve");
    idle(2);
    check("R6 dropped results", exp_q.size(), 0);

    // R7: restart mid-window discards partial sum
    do_restart(5, 0, 0);
    for (int i = 0; i < 3; i++) word(32'hFFFFFFFF, 1, "R7 partial");
    do_restart(5, 0, 0);
    for (int i = 0; i < 8; i++) word(32'h10101010, 1, "R7 after restart");
    idle(2);

    // R8: config changes without restart have no effect
    do_restart(3, 0, 0);
    word(32'h01020304, 1, "R8 cfg ignored");
    @(negedge clk);
    cfg_log_win = 4'd8; cfg_gain2x = 1'b1; cfg_halve = 1'b1; in_valid = 1'b0;
    word(32'h90A0B0C0, 1, "R8 cfg ignored");
    for (int i = 0; i < 4; i++) word($urandom, 1, "R8 cfg ignored");
    idle(2);

    // R9: illegal window settings
    do_restart(1, 0, 0);
    @(negedge clk); restart = 1'b0; in_valid = 1'b0;
    check("R9 flag n=1", cfg_illegal, 1);
    for (int i = 0; i < 6; i++) word($urandom, 1, "R9 must not emit");
    do_restart(9, 0, 0);
    @(negedge clk); restart = 1'b0; in_valid = 1'b0;
    check("R9 flag n=9", cfg_illegal, 1);
    for (int i = 0; i < 6; i++) word($urandom, 1, "R9 must not emit");
    do_restart(2, 0, 0);
    @(negedge clk); restart = 1'b0; in_valid = 1'b0;
    check("R9 flag cleared", cfg_illegal, 0);
    word(32'h08080808, 1, "R9 legal again");
    idle(3);

    check("R3 all results seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule